// File: doc/BRIEF.md
# Serial EEPROM Command Front End

This block is the slave side of a 512-byte serial EEPROM on an SPI bus, SCK mode 0. The bus pins are sampled in the system clock domain. The block shifts in an 8-bit opcode and decodes it, then runs that command's phases: array read, array write, setting or clearing the write-enable latch, status read and status write. Read data comes from an internal 512x8 array with synchronous read. It is shifted out MSB first, and the read address advances by one after each byte.

Writes are split between this block and a separate page-write engine. The front end hands each received data byte and its address to the engine. When chip select rises, the front end either commits the staged page or drops it. The engine reports its write cycle on `eng_busy` and stores bytes into the array through the array write port. SCK high and low phases must each last at least three system clocks.

Top module: `spi_ee_front`

## Requirements
- R1: SI is captured on each sampled SCK rising edge while `cs_n` is low and `hold_n` is high, starting with the first rise after `cs_n` falls. All bytes are MSB first. The first byte of a frame is the opcode: 0x06 sets the latch, 0x04 clears it, 0x05 reads status, 0x01 writes status, `0000_A011` reads and `0000_A010` writes, where bit 3 (A) is address bit 8.
- R2: After a read opcode, the next byte gives address bits 7:0. From the following SCK fall, SO presents the stored byte at that address MSB first, changing after each SCK fall.
- R3: A read continues while SCK runs, taking the next address for every further byte, and wraps from 0x1FF to 0x000.
- R4: The write-enable latch (WEL) is set only when `cs_n` rises after exactly eight bits of a 0x06 opcode. A frame in which 0x06 is followed by further bits leaves WEL clear and causes no array write.
- R5: WEL is cleared by opcode 0x04 and by the falling edge of `eng_busy`.
- R6: A write frame is accepted only when WEL is set, `wp_n` is high and `eng_busy` is low. Each complete data byte then gives a one-cycle `pw_load` with `pw_addr` and `pw_data`. The address's low 4 bits wrap within the 16-byte page.
- R7: When `cs_n` rises in an accepted write frame on a byte boundary with at least one data byte, the block pulses `pw_commit`. In any other case it pulses `pw_drop`, never both.
- R8: The status byte is {4'b0000, BP1, BP0, WEL, WIP}, with WIP equal to `eng_busy`. It repeats while SCK runs and can be read during a write cycle.
- R9: Opcode 0x01 followed by a data byte copies data bits 3:2 into BP1:BP0, only when WEL is set and `wp_n` is high.
- R10: While `hold_n` is low, SCK edges are ignored, all state is kept and `so_oe` is low. Once `hold_n` is high again, the transfer resumes at the bit where it stopped.
- R11: A read opcode received while `eng_busy` is high returns no array data: `so_oe` stays low for the whole frame.
- R12: `so_oe` is low while `cs_n` is high, while `hold_n` is low, and outside a read or status data phase.
- R13: A rise of `cs_n` at any point ends the current command, and the next frame starts with an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock (mode 0) |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| wp_n | input | 1 | Write protect, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` |
| eng_busy | input | 1 | Write cycle in progress in the page-write engine |
| arr_we | input | 1 | Array write strobe from the engine |
| arr_waddr | input | 9 | Array write address |
| arr_wdata | input | 8 | Array write data |
| pw_load | output | 1 | One-cycle pulse: a data byte is staged |
| pw_addr | output | 9 | Address of the staged byte |
| pw_data | output | 8 | Staged data byte |
| pw_commit | output | 1 | One-cycle pulse: program the staged page |
| pw_drop | output | 1 | One-cycle pulse: discard the staged page |

## Verification
The bench targets the corner cases of the write-enable latch. If chip select does not gate the latch, a WREN followed by more bits in the same frame, or a write sent in the same frame as WREN, would still set the latch and lead to a write. It checks a page write that starts at offset 0xD. Without the in-page wrap, the design would carry into the next page's address. It checks a read from 0x1FE. Without the 9-bit wrap, the design would return the wrong bytes after 0x1FF. Frames cut mid-byte must give a drop and no commit. Reads and status reads during the busy window, writes under write protect, and a HOLD pause in the middle of a byte are also checked. A design that shifts SCK during the pause would corrupt the byte it returns.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  localparam logic [7:0] OPC_LATCH_ON  = 8'h06;
  localparam logic [7:0] OPC_LATCH_OFF = 8'h04;
  localparam logic [7:0] OPC_STAT_RD   = 8'h05;
  localparam logic [7:0] OPC_STAT_WR   = 8'h01;

  typedef enum logic [3:0] {
    PH_OP, PH_RADDR, PH_WADDR, PH_RDAT, PH_WDAT,
    PH_SDAT, PH_WSR, PH_WEN, PH_SKIP
  } ph_t;
endpackage

// File: rtl/ee_sck_edge.sv
module ee_sck_edge (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic hold_n,
  output logic rise,
  output logic fall,
  output logic cs_up
);
  logic sck_q, cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
    end
  end

  assign rise  = sck & ~sck_q & ~cs_n & hold_n;
  assign fall  = ~sck & sck_q & ~cs_n & hold_n;
  assign cs_up = cs_n & ~cs_q;
endmodule

// File: rtl/ee_status.sv
module ee_status #(
  parameter int BP_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_wel,
  input  logic            clr_wel,
  input  logic            busy,
  input  logic            bp_we,
  input  logic [BP_W-1:0] bp_d,
  output logic            wel,
  output logic [BP_W-1:0] bp
);
  logic busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wel    <= 1'b0;
      bp     <= '0;
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy;
      if (clr_wel || (busy_q && !busy)) wel <= 1'b0;
      else if (set_wel)                 wel <= 1'b1;
      if (bp_we) bp <= bp_d;
    end
  end

  // R5: end of a write cycle leaves the latch cleared
  p_wel_clr_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !busy) |=> !wel);
endmodule

// File: rtl/ee_array.sv
module ee_array #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spi_ee_front.sv
module spi_ee_front
  import spi_ee_pkg::*;
#(
  parameter int DW     = 8,
  parameter int PAGE_W = 4,
  parameter int BP_W   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          si,
  input  logic          hold_n,
  input  logic          wp_n,
  output logic          so,
  output logic          so_oe,
  input  logic          eng_busy,
  input  logic          arr_we,
  input  logic [DW:0]   arr_waddr,
  input  logic [DW-1:0] arr_wdata,
  output logic          pw_load,
  output logic [DW:0]   pw_addr,
  output logic [DW-1:0] pw_data,
  output logic          pw_commit,
  output logic          pw_drop
);
  localparam int AW    = DW + 1;
  localparam int CW    = $clog2(DW);
  localparam int PAD_W = DW - 2 - BP_W;

  logic            rise, fall, cs_up;
  ph_t             ph;
  logic [CW-1:0]   bit_cnt;
  logic [DW-2:0]   shreg;
  logic [DW-1:0]   byte_in, tx, rdata, stat, load_src;
  logic            byte_done, is_read, is_write;
  logic            a8, got_byte, txact, so_r, oe_r;
  logic [AW-1:0]   rd_addr, wr_addr;
  logic            wel, set_wel, clr_wel, bp_we;
  logic [BP_W-1:0] bp;

  ee_sck_edge u_edge (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
    .rise(rise), .fall(fall), .cs_up(cs_up)
  );

  ee_status #(.BP_W(BP_W)) u_stat (
    .clk(clk), .rst(rst), .set_wel(set_wel), .clr_wel(clr_wel),
    .busy(eng_busy), .bp_we(bp_we), .bp_d(byte_in[2 +: BP_W]),
    .wel(wel), .bp(bp)
  );

  ee_array #(.AW(AW), .DW(DW)) u_arr (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .raddr(rd_addr), .rdata(rdata)
  );

  always_comb begin
    byte_in   = {shreg, si};
    byte_done = rise && (bit_cnt == CW'(DW - 1));
    is_read   = (byte_in[7:4] == 4'h0) && (byte_in[2:0] == 3'b011);
    is_write  = (byte_in[7:4] == 4'h0) && (byte_in[2:0] == 3'b010);
    set_wel   = cs_up && (ph == PH_WEN);
    clr_wel   = byte_done && (ph == PH_OP) && (byte_in == OPC_LATCH_OFF);
    bp_we     = byte_done && (ph == PH_WSR) && wel && wp_n;
    stat      = {{PAD_W{1'b0}}, bp, wel, eng_busy};
    load_src  = (ph == PH_RDAT) ? rdata : stat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_OP;  bit_cnt <= '0;  shreg <= '0;  tx <= '0;
      a8 <= 1'b0;   got_byte <= 1'b0; txact <= 1'b0;
      so_r <= 1'b0; oe_r <= 1'b0;
      rd_addr <= '0; wr_addr <= '0;
      pw_load <= 1'b0; pw_addr <= '0; pw_data <= '0;
      pw_commit <= 1'b0; pw_drop <= 1'b0;
    end else begin
      pw_load   <= 1'b0;
      pw_commit <= 1'b0;
      pw_drop   <= 1'b0;
      oe_r      <= ~cs_n & hold_n & txact;
      if (cs_n) begin
        if (cs_up && ph == PH_WDAT) begin
          if (bit_cnt == '0 && got_byte) pw_commit <= 1'b1;
          else                           pw_drop   <= 1'b1;
        end else if (cs_up && ph == PH_WADDR) begin
          pw_drop <= 1'b1;
        end
        ph <= PH_OP;  bit_cnt <= '0;  txact <= 1'b0;
        so_r <= 1'b0; got_byte <= 1'b0;
      end else begin
        if (rise) begin
          shreg   <= byte_in[DW-2:0];
          bit_cnt <= byte_done ? '0 : bit_cnt + 1'b1;
          if (ph == PH_WEN) ph <= PH_SKIP;
          if (byte_done) begin
            case (ph)
              PH_OP: begin
                a8 <= byte_in[3];
                if (is_read)                        ph <= eng_busy ? PH_SKIP : PH_RADDR;
                else if (is_write)                  ph <= (wel && wp_n && !eng_busy) ? PH_WADDR : PH_SKIP;
                else if (byte_in == OPC_LATCH_ON)   ph <= PH_WEN;
                else if (byte_in == OPC_STAT_RD)    ph <= PH_SDAT;
                else if (byte_in == OPC_STAT_WR)    ph <= PH_WSR;
                else                                ph <= PH_SKIP;
              end
              PH_RADDR: begin
                rd_addr <= {a8, byte_in};
                ph      <= PH_RDAT;
              end
              PH_WADDR: begin
                wr_addr <= {a8, byte_in};
                ph      <= PH_WDAT;
              end
              PH_WDAT: begin
                pw_load  <= 1'b1;
                pw_addr  <= wr_addr;
                pw_data  <= byte_in;
                got_byte <= 1'b1;
                wr_addr  <= {wr_addr[AW-1:PAGE_W], wr_addr[PAGE_W-1:0] + 1'b1};
              end
              PH_WSR:  ph <= PH_SKIP;
              default: ;
            endcase
          end
        end
        if (fall && (ph == PH_RDAT || ph == PH_SDAT)) begin
          if (bit_cnt == '0) begin
            so_r  <= load_src[DW-1];
            tx    <= {load_src[DW-2:0], 1'b0};
            txact <= 1'b1;
            if (ph == PH_RDAT) rd_addr <= rd_addr + 1'b1;
          end else begin
            so_r <= tx[DW-1];
            tx   <= {tx[DW-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign so    = so_r;
  assign so_oe = oe_r;

  p_oe_cs_r12: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !so_oe);
  p_oe_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !hold_n |=> !so_oe);
  p_hold_freeze_r10: assert property (@(posedge clk) disable iff (rst)
    (!hold_n && !cs_n) |=> ($stable(bit_cnt) && $stable(tx) && $stable(ph)));
  p_wel_set_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(wel) |-> $past(cs_n));
  p_load_wel_r6: assert property (@(posedge clk) disable iff (rst)
    pw_load |-> (wel && !eng_busy));
  p_commit_once_r7: assert property (@(posedge clk) disable iff (rst)
    pw_commit |-> (!pw_drop && $past(cs_n)));
endmodule

// File: tb/spi_ee_front_bench.sv
module spi_ee_front_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  logic so, so_oe;
  logic eng_busy = 1'b0, arr_we = 1'b0;
  logic [8:0] arr_waddr = '0;
  logic [7:0] arr_wdata = '0;
  logic pw_load, pw_commit, pw_drop;
  logic [8:0] pw_addr;
  logic [7:0] pw_data;

  always #2.5 clk = ~clk;

  spi_ee_front u_spi_ee_front (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe),
    .eng_busy(eng_busy), .arr_we(arr_we), .arr_waddr(arr_waddr),
    .arr_wdata(arr_wdata), .pw_load(pw_load), .pw_addr(pw_addr),
    .pw_data(pw_data), .pw_commit(pw_commit), .pw_drop(pw_drop)
  );

  int checks = 0, errors = 0;
  int n_commit = 0, n_drop = 0;
  logic [7:0]  model [512];
  logic [16:0] exp_q [$];
  logic        fill_done = 1'b0;
  logic        oe_any;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Monitor: compares staged bytes against the scoreboard queue
  always @(negedge clk) begin
    if (!rst) begin
      if (pw_commit) n_commit++;
      if (pw_drop)   n_drop++;
      if (pw_load) begin
        if (exp_q.size() == 0) chk(0, "R6 unexpected load", {pw_addr, pw_data}, 0);
        else begin
          logic [16:0] e;
          e = exp_q.pop_front();
          chk({pw_addr, pw_data} == e, "R6 staged byte", {pw_addr, pw_data}, e);
        end
      end
    end
  end

  // Page-write engine model: initial fill, then staged commits
  initial begin
    logic [8:0] sa [16];
    logic [7:0] sd [16];
    int sn;
    sn = 0;
    @(negedge clk);
    for (int a = 0; a < 512; a++) begin
      arr_we = 1'b1; arr_waddr = 9'(a); arr_wdata = 8'(a * 7 + 3);
      @(negedge clk);
    end
    arr_we = 1'b0;
    fill_done = 1'b1;
    forever begin
      @(negedge clk);
      if (pw_drop) sn = 0;
      if (pw_load && sn < 16) begin sa[sn] = pw_addr; sd[sn] = pw_data; sn++; end
      if (pw_commit) begin
        eng_busy = 1'b1;
        repeat (600) @(negedge clk);
        for (int k = 0; k < sn; k++) begin
          arr_we = 1'b1; arr_waddr = sa[k]; arr_wdata = sd[k];
          @(negedge clk);
        end
        arr_we = 1'b0; sn = 0; eng_busy = 1'b0;
      end
    end
  end

  task automatic xbits(input logic [7:0] t, input int nb, input int hold_bit, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      si = t[i];
      repeat (4) @(negedge clk);
      r[i] = so;
      if (so_oe) oe_any = 1'b1;
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
      if (i == hold_bit) begin
        repeat (2) @(negedge clk);
        hold_n = 1'b0;
        repeat (2) @(negedge clk);
        sck = 1'b1;
        repeat (3) @(negedge clk);
        chk(so_oe == 1'b0, "R10 oe during pause", so_oe, 0);
        sck = 1'b0;
        repeat (3) @(negedge clk);
        hold_n = 1'b1;
      end
    end
  endtask

  task automatic xb(input logic [7:0] t, output logic [7:0] r);
    xbits(t, 8, -1, r);
  endtask

  task automatic cs_lo();
    oe_any = 1'b0;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] r;
    cs_lo(); xb(op, r); cs_hi();
  endtask

  task automatic stat_chk(input logic [7:0] exp, input string req);
    logic [7:0] r;
    cs_lo(); xb(8'h05, r); xb(8'h00, r); cs_hi();
    chk(r == exp, req, r, exp);
  endtask

  task automatic read_chk(input logic [8:0] addr, input int n, input string req);
    logic [7:0] r;
    cs_lo();
    xb({4'h0, addr[8], 3'b011}, r);
    xb(addr[7:0], r);
    for (int k = 0; k < n; k++) begin
      logic [8:0] a;
      a = addr + 9'(k);
      xb(8'h00, r);
      chk(r == model[a], req, r, model[a]);
    end
    cs_hi();
  endtask

  task automatic wait_idle();
    while (eng_busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin : wd
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R13 watchdog: actual 0x1 expected 0x0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int c0, d0;
    for (int a = 0; a < 512; a++) model[a] = 8'(a * 7 + 3);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(so_oe == 1'b0, "R12 reset oe", so_oe, 0);
    chk(pw_load == 1'b0 && pw_commit == 1'b0 && pw_drop == 1'b0, "R7 reset pulses",
        {pw_load, pw_commit, pw_drop}, 0);
    while (!fill_done) @(negedge clk);
    repeat (4) @(negedge clk);

    stat_chk(8'h00, "R1 R8 status after reset");
    cmd(8'h06);
    stat_chk(8'h02, "R4 latch set");
    cmd(8'h04);
    stat_chk(8'h00, "R5 latch cleared by 0x04");

    // R4: extra bits after WREN in the same frame
    cs_lo(); xb(8'h06, r); xb(8'h00, r); cs_hi();
    stat_chk(8'h00, "R4 extra bits keep latch clear");

    // R4: write in the same frame as WREN must not reach the engine
    c0 = n_commit;
    cs_lo(); xb(8'h06, r); xb(8'h02, r); xb(8'h40, r); xb(8'h5A, r); cs_hi();
    chk(n_commit == c0, "R4 no commit same frame", n_commit, c0);
    stat_chk(8'h00, "R4 latch still clear");

    read_chk(9'h0F0, 4, "R2 read low half");
    read_chk(9'h1FE, 4, "R3 read wrap");
    chk(oe_any == 1'b1, "R2 oe during read", oe_any, 1);

    // R6/R7: page write from offset 0xD wraps in page
    cmd(8'h06);
    c0 = n_commit;
    cs_lo();
    xb(8'h0A, r); xb(8'h0D, r);
    for (int k = 0; k < 5; k++) begin
      logic [8:0] a;
      a = {5'h10, 4'(4'hD + k)};
      exp_q.push_back({a, 8'(8'hA0 + k)});
      xb(8'(8'hA0 + k), r);
    end
    cs_hi();
    chk(n_commit == c0 + 1, "R7 commit on boundary", n_commit, c0 + 1);
    stat_chk(8'h03, "R8 status during write cycle");
    cs_lo(); xb(8'h0B, r); xb(8'h0D, r); xb(8'h00, r); cs_hi();
    chk(oe_any == 1'b0, "R11 no data while busy", oe_any, 0);
    chk(eng_busy == 1'b1, "R11 read was inside busy window", eng_busy, 1);
    wait_idle();
    for (int k = 0; k < 5; k++) model[{5'h10, 4'(4'hD + k)}] = 8'(8'hA0 + k);
    stat_chk(8'h00, "R5 latch cleared after write cycle");
    read_chk(9'h10C, 6, "R6 page wrap read back");
    chk(exp_q.size() == 0, "R6 all loads seen", exp_q.size(), 0);

    // R7/R13: frame cut mid-byte
    cmd(8'h06);
    c0 = n_commit; d0 = n_drop;
    exp_q.push_back({9'h020, 8'h77});
    cs_lo(); xb(8'h02, r); xb(8'h20, r); xb(8'h77, r); xbits(8'hFF, 3, -1, r); cs_hi();
    chk(n_drop == d0 + 1 && n_commit == c0, "R7 drop on partial byte", n_drop - d0, 1);
    stat_chk(8'h02, "R7 latch kept after drop");
    cs_lo(); xbits(8'h05, 3, -1, r); cs_hi();
    stat_chk(8'h02, "R13 decoder restarts after cut");
    read_chk(9'h020, 1, "R7 array untouched");

    // R6/R9: write protect
    wp_n = 1'b0;
    c0 = n_commit;
    cs_lo(); xb(8'h02, r); xb(8'h30, r); xb(8'h11, r); cs_hi();
    chk(n_commit == c0, "R6 write blocked by protect", n_commit, c0);
    cs_lo(); xb(8'h01, r); xb(8'h0C, r); cs_hi();
    stat_chk(8'h02, "R9 status write blocked by protect");
    wp_n = 1'b1;

    cs_lo(); xb(8'h01, r); xb(8'hFF, r); cs_hi();
    stat_chk(8'h0E, "R9 BP bits written");
    cmd(8'h04);
    stat_chk(8'h0C, "R5 R9 latch off, BP kept");
    cs_lo(); xb(8'h01, r); xb(8'h00, r); cs_hi();
    stat_chk(8'h0C, "R9 no update without latch");
    cmd(8'h06);
    cs_lo(); xb(8'h01, r); xb(8'h00, r); cs_hi();
    stat_chk(8'h02, "R9 BP cleared");
    cmd(8'h04);

    // R10: pause in the middle of a data byte
    cs_lo();
    xb(8'h03, r); xb(8'hF0, r);
    xbits(8'h00, 8, 4, r);
    chk(r == model[9'h0F0], "R10 byte across pause", r, model[9'h0F0]);
    xb(8'h00, r);
    chk(r == model[9'h0F1], "R10 next byte after pause", r, model[9'h0F1]);
    cs_hi();
    @(negedge clk);
    chk(so_oe == 1'b0, "R12 oe off after frame", so_oe, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule